// File: doc/BRIEF.md
# Signed Countdown Timer with Emulated Absolute Compare

This block is a per-core timer that offers software an absolute 64-bit compare deadline. Internally it holds only a 32-bit countdown value, which it treats as a two's-complement signed number. A free-running 64-bit system count arrives on the `sys_count` input, together with a one-cycle `count_tick` strobe that marks each advance of that count.

Writing an absolute deadline loads the countdown with the low 32 bits of the deadline minus the present count. Reading the deadline back rebuilds it as the present count plus the sign-extended countdown. The timer condition holds whenever the countdown is negative. This has two consequences. A deadline 2^31 or more ticks away fires at once. A condition that is left unserviced clears again when the countdown wraps from its most negative value back to a large positive one.

At a 50 MHz count, the usable range is just under 43 seconds. Register access uses a plain single-cycle write strobe and a combinational read mux. There is no stream data, so the block has no valid/ready handshake.

Top module: `sig_cdown_timer`

## Requirements
- R1: After reset the countdown is 0, enable and mask are 0, and both `irq` and `status` are 0.
- R2: A write with `wr_sel`=0 stores `wr_data[0]` as enable and `wr_data[1]` as mask. A read with `rd_sel`=0 returns enable in bit 0, mask in bit 1 and status in bit 2, with all other bits 0.
- R3: A write with `wr_sel`=2 loads the countdown with `wr_data[31:0]` unchanged. A read with `rd_sel`=2 returns the countdown sign-extended to 64 bits. If a write and a tick happen in the same cycle, the write wins.
- R4: Each cycle with `count_tick` high and no countdown write decrements the countdown by exactly one, modulo 2^32. Cycles with no tick leave it unchanged.
- R5: A write with `wr_sel`=1 loads the countdown with the low 32 bits of `wr_data - sys_count`.
- R6: A read with `rd_sel`=1 returns `sys_count` plus the sign-extended countdown, modulo 2^64. An unused select (3) reads 0.
- R7: `status` equals enable AND countdown bit 31. A deadline whose delta has bit 31 set therefore fires immediately.
- R8: `irq` is a level equal to `status` AND NOT mask.
- R9: With enable low the countdown keeps decrementing on ticks, while `status` and `irq` stay 0.
- R10: A tick taken at countdown 0x80000000 gives 0x7FFFFFFF, which clears `status` and `irq`: the pending condition is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_count | input | 64 | Free-running system count |
| count_tick | input | 1 | One-cycle strobe: the count advanced |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 deadline, 2 countdown |
| wr_data | input | 64 | Write data |
| rd_sel | input | 2 | Read target, same encoding as `wr_sel` |
| rd_data | output | 64 | Combinational read data |
| status | output | 1 | Timer condition qualified by enable |
| irq | output | 1 | Level interrupt, status gated by mask |

## Verification
A wrong countdown value is visible on the port in the same cycle it arises. It shows through the countdown readback, the rebuilt deadline and `status`, so a missed or doubled decrement is caught at the next sample after a tick. Sign-handling faults appear only at the 0x80000000 and 0x00000000 boundaries. For that reason the bench programs values next to those points and steps single ticks across them. Enable and mask faults show on `status` and `irq` at once, while the countdown is negative.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CVAL = 2'd1,
    SEL_TVAL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cdt_ctrl_reg.sv
module cdt_ctrl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic [1:0] wr_bits,
  output logic       en,
  output logic       mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      mask <= 1'b0;
    end else if (wr_ctrl) begin
      en   <= wr_bits[0];
      mask <= wr_bits[1];
    end
  end

  // R2: control write takes effect on the next cycle
  a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (en == $past(wr_bits[0])) && (mask == $past(wr_bits[1])));
endmodule

// File: rtl/cdt_countdown.sv
module cdt_countdown #(
  parameter int CNT_W = 64,
  parameter int TV_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_tval,
  input  logic             load_cval,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] sys_count,
  output logic [TV_W-1:0]  tval
);
  logic [CNT_W-1:0] delta;
  logic [TV_W-1:0]  load_value;
  logic             load;

  assign delta      = wr_data - sys_count;
  assign load       = load_tval || load_cval;
  assign load_value = load_cval ? delta[TV_W-1:0] : wr_data[TV_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tval <= '0;
    else if (load) tval <= load_value;
    else if (tick) tval <= tval - TV_W'(1);
  end

  // R4: one tick, one step down
  a_r4_tick_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> tval == $past(tval) - TV_W'(1));
  // R4: no tick, no change
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(tval));
  // R3: a direct write wins over a tick
  a_r3_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_tval |=> tval == $past(wr_data[TV_W-1:0]));
  // R5: deadline write loads the truncated difference
  a_r5_cval_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_cval |=> tval == $past(wr_data[TV_W-1:0] - sys_count[TV_W-1:0]));
endmodule

// File: rtl/cdt_readmux.sv
module cdt_readmux
  import cdt_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int TV_W  = 32
) (
  input  logic [1:0]       rd_sel,
  input  logic             en,
  input  logic             mask,
  input  logic             status,
  input  logic [TV_W-1:0]  tval,
  input  logic [CNT_W-1:0] sys_count,
  output logic [CNT_W-1:0] rd_data
);
  localparam int EXT_W = CNT_W - TV_W;
  logic [CNT_W-1:0] tval_sext;

  assign tval_sext = {{EXT_W{tval[TV_W-1]}}, tval};

  always_comb begin
    unique case (reg_sel_e'(rd_sel))
      SEL_CTRL: rd_data = {{(CNT_W-3){1'b0}}, status, mask, en};
      SEL_CVAL: rd_data = sys_count + tval_sext;
      SEL_TVAL: rd_data = tval_sext;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/sig_cdown_timer.sv
module sig_cdown_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int TV_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] sys_count,
  input  logic             count_tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             status,
  output logic             irq
);
  logic            en, mask;
  logic [TV_W-1:0] tval;
  logic            wr_ctrl, load_cval, load_tval;

  assign wr_ctrl   = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
  assign load_cval = wr_en && (reg_sel_e'(wr_sel) == SEL_CVAL);
  assign load_tval = wr_en && (reg_sel_e'(wr_sel) == SEL_TVAL);

  cdt_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_bits(wr_data[1:0]),
    .en(en), .mask(mask)
  );

  cdt_countdown #(.CNT_W(CNT_W), .TV_W(TV_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(count_tick), .load_tval(load_tval),
    .load_cval(load_cval), .wr_data(wr_data), .sys_count(sys_count), .tval(tval)
  );

  assign status = en && tval[TV_W-1];
  assign irq    = status && !mask;

  cdt_readmux #(.CNT_W(CNT_W), .TV_W(TV_W)) u_rd (
    .rd_sel(rd_sel), .en(en), .mask(mask), .status(status), .tval(tval),
    .sys_count(sys_count), .rd_data(rd_data)
  );

  // R8: interrupt only while the countdown is negative
  a_r8_irq_needs_negative: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> tval[TV_W-1]);
  // R9: disabled timer never signals
  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !status && !irq);
  // R10: wrap from most negative to positive drops the condition
  a_r10_wrap_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (count_tick && !wr_en && tval == {1'b1, {(TV_W-1){1'b0}}}) |=> !status);
endmodule

// File: tb/sim_sig_cdown_timer.sv
module sim_sig_cdown_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] sys_count = 64'd0;
  logic        count_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [63:0] wr_data = 64'd0;
  logic [1:0]  rd_sel = 2'd0;
  logic [63:0] rd_data;
  logic        status, irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sig_cdown_timer u0 (
    .clk(clk), .rst_n(rst_n), .sys_count(sys_count), .count_tick(count_tick),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .status(status), .irq(irq)
  );

  function automatic logic [63:0] sx(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [63:0] d, input bit tk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; count_tick = tk;
    @(negedge clk);
    wr_en = 1'b0; count_tick = 1'b0;
    if (tk) sys_count = sys_count + 64'd1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      count_tick = 1'b1;
      @(negedge clk);
      count_tick = 1'b0;
      sys_count = sys_count + 64'd1;
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [63:0] v);
    rd_sel = sel; #1; v = rd_data;
  endtask

  task automatic t_reset();
    logic [63:0] v;
    rd(2'd0, v); chk("R1 ctrl", v, 64'd0);
    rd(2'd2, v); chk("R1 tval", v, 64'd0);
    chk("R1 irq/status", {62'd0, irq, status}, 64'd0);
  endtask

  task automatic t_ctrl();
    logic [63:0] v;
    wr(2'd0, 64'hFFFF_FFFF_FFFF_FFF3, 0);
    rd(2'd0, v); chk("R2 ctrl readback", v, 64'd3);
    rd(2'd3, v); chk("R6 unused select", v, 64'd0);
    wr(2'd0, 64'd0, 0);
  endtask

  task automatic t_tval();
    logic [63:0] v;
    wr(2'd2, 64'hABCD_0000_0000_0064, 0);
    rd(2'd2, v); chk("R3 tval write", v, 64'd100);
    wr(2'd2, 64'd55, 1);
    rd(2'd2, v); chk("R3 write wins over tick", v, 64'd55);
    ticks(5);
    rd(2'd2, v); chk("R4 five ticks", v, 64'd50);
    repeat (3) @(negedge clk);
    rd(2'd2, v); chk("R4 no tick hold", v, 64'd50);
    wr(2'd2, 64'd0, 0); ticks(1);
    rd(2'd2, v); chk("R4 wrap below zero", v, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_cval();
    logic [63:0] v;
    sys_count = 64'h0000_0012_0000_03E8;
    wr(2'd1, 64'h0000_0012_0000_05DC, 0);
    rd(2'd2, v); chk("R5 cval delta", v, 64'd500);
    rd(2'd1, v); chk("R6 cval readback", v, 64'h0000_0012_0000_05DC);
    ticks(3);
    rd(2'd1, v); chk("R6 cval stable over ticks", v, 64'h0000_0012_0000_05DC);
  endtask

  task automatic t_fire();
    logic [63:0] v;
    wr(2'd0, 64'd1, 0);
    wr(2'd2, 64'd2, 0);
    ticks(2);
    chk("R7 zero not fired", {62'd0, irq, status}, 64'd0);
    ticks(1);
    rd(2'd2, v); chk("R7 tval -1", v, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R7/R8 fired", {62'd0, irq, status}, 64'd3);
    rd(2'd0, v); chk("R2 status bit", v, 64'd5);
    wr(2'd0, 64'd3, 0);
    chk("R8 masked", {62'd0, irq, status}, 64'd1);
    wr(2'd0, 64'd1, 0);
  endtask

  task automatic t_far();
    wr(2'd1, sys_count + 64'h8000_0000, 0);
    chk("R7 far deadline fires at once", {62'd0, irq, status}, 64'd3);
  endtask

  task automatic t_disable();
    logic [63:0] v;
    wr(2'd2, 64'hFFFF_FFF0, 0);
    wr(2'd0, 64'd0, 0);
    chk("R9 disabled quiet", {62'd0, irq, status}, 64'd0);
    ticks(4);
    rd(2'd2, v); chk("R9 counts while disabled", v, sx(32'hFFFF_FFEC));
    wr(2'd0, 64'd1, 0);
  endtask

  task automatic t_wrap();
    logic [63:0] v;
    wr(2'd2, 64'h8000_0000, 0);
    chk("R10 most negative fired", {62'd0, irq, status}, 64'd3);
    ticks(1);
    rd(2'd2, v); chk("R10 wrap value", v, 64'h7FFF_FFFF);
    chk("R10 condition lost", {62'd0, irq, status}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_tval();
    t_cval();
    t_fire();
    t_far();
    t_disable();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule